// File: doc/BRIEF.md
# SCSI Bus Phase and Parity Interrupt Logic

This block watches the control and data lines of a SCSI bus on behalf of a controller and produces status flags and one interrupt request. It compares the live phase lines (I/O, C/D, MSG) against the phase the controller has programmed in its target command value, and reports the result continuously. In DMA mode, the start of each REQ assertion is checked against that programmed phase. A mismatch at that moment raises the interrupt.

It also checks odd parity on received bytes. This happens only when the controller reads its data register or takes a DMA receive transfer. A parity error sets a sticky flag whenever checking is enabled. The interrupt follows only when the parity interrupt enable is also set. Both sticky bits stay set until an acknowledge pulse clears them. The bus pins are active low and pass through a two-flop synchronizer before they are used.

Top module: `scsi_stat_irq`

## Requirements
- R1: `phase_match_o` is 1 exactly when each asserted phase line (pin low) equals its command bit: I/O with `tcmd_i[0]`, C/D with `tcmd_i[1]`, MSG with `tcmd_i[2]`.
- R2: The phase comparison runs all the time, whatever REQ and the mode are. A change of `tcmd_i` shows on `phase_match_o` in the same cycle. A change of a phase pin shows within three clock edges.
- R3: With `mode_i[1]` (DMA mode) set, an interrupt is raised when REQ goes from deasserted to asserted while the phase does not match.
- R4: No phase interrupt is raised in three cases: `mode_i[1]` is clear, the phase matches at the REQ assertion edge, or a mismatch appears while REQ stays asserted.
- R5: Parity is odd over the true sense of the 8 data bits and DBP. An error is detected only during a `dreg_rd_i` or `dma_rx_i` strobe, and only while `mode_i[5]` is set. Good parity never sets the flag.
- R6: A parity error raises the interrupt only when `mode_i[4]` is also set. With `mode_i[4]` clear, it sets `parity_err_o` and leaves `irq_o` low.
- R7: `parity_err_o` and `irq_active_o` hold until an `ack_i` pulse clears them. An event in the same cycle as the pulse wins. `irq_o` equals `irq_active_o`.
- R8: A parity error and a phase mismatch edge in the same cycle raise one interrupt and set each related flag.
- R9: After reset, `parity_err_o`, `irq_active_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | Bus REQ, active low |
| io_ni | input | 1 | Bus I/O phase line, active low |
| cd_ni | input | 1 | Bus C/D phase line, active low |
| msg_ni | input | 1 | Bus MSG phase line, active low |
| dbp_ni | input | 1 | Bus data parity, active low |
| data_ni | input | 8 | Bus data, active low |
| mode_i | input | 8 | Mode value: bit 1 DMA mode, bit 4 parity interrupt enable, bit 5 parity check enable |
| tcmd_i | input | 8 | Target command value: bit 0 I/O, bit 1 C/D, bit 2 MSG |
| dreg_rd_i | input | 1 | Data register read strobe |
| dma_rx_i | input | 1 | DMA receive strobe |
| ack_i | input | 1 | Clears the sticky flags |
| phase_match_o | output | 1 | Bus phase equals programmed phase |
| parity_err_o | output | 1 | Sticky parity error flag |
| irq_active_o | output | 1 | Sticky interrupt active bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The phase comparator is driven through all eight command codes with matching lines. Each line is then flipped alone, which tells a comparator that ignores one bit, or swaps two bits, from a correct one. The interrupt path is driven with four patterns: a mismatched REQ edge in DMA mode, the same edge without DMA mode, a matched edge, and a mismatch that arises under a held REQ. Together they separate edge detection from level detection and show that the DMA mode gate is present. Parity is tried with good and bad bytes under both strobes, with checking off and with the interrupt enable off. This isolates each enable. A same-cycle parity and phase event confirms that the sources merge into one interrupt.

// File: rtl/scsi_stat_pkg.sv
package scsi_stat_pkg;
  localparam int MODE_DMA_BIT  = 1;
  localparam int MODE_PIRQ_BIT = 4;
  localparam int MODE_PCHK_BIT = 5;
  localparam int TC_IO_BIT     = 0;
  localparam int TC_CD_BIT     = 1;
  localparam int TC_MSG_BIT    = 2;

  typedef struct packed {
    logic msg;
    logic cd;
    logic io;
  } phase_t;
endpackage

// File: rtl/scsi_line_sync.sv
module scsi_line_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scsi_phase_cmp.sv
module scsi_phase_cmp
  import scsi_stat_pkg::*;
(
  input  phase_t bus_ph_i,
  input  phase_t cmd_ph_i,
  output logic   match_o
);
  assign match_o = (bus_ph_i == cmd_ph_i);
endmodule

// File: rtl/scsi_parity_chk.sv
module scsi_parity_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              strobe_i,
  input  logic              chk_en_i,
  output logic              err_o
);
  logic odd_ok;
  assign odd_ok = ^{data_i, par_i};
  assign err_o  = strobe_i && chk_en_i && !odd_ok;
endmodule

// File: rtl/scsi_irq_ctl.sv
module scsi_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic match_i,
  input  logic dma_mode_i,
  input  logic perr_i,
  input  logic pirq_en_i,
  input  logic ack_i,
  output logic perr_o,
  output logic irq_act_o
);
  logic req_q, req_rise, ph_irq, p_irq;

  assign req_rise = req_i && !req_q;
  assign ph_irq   = dma_mode_i && req_rise && !match_i;
  assign p_irq    = perr_i && pirq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      perr_o    <= 1'b0;
      irq_act_o <= 1'b0;
    end else begin
      req_q <= req_i;
      // new events take precedence over acknowledge
      if (perr_i)     perr_o <= 1'b1;
      else if (ack_i) perr_o <= 1'b0;
      if (ph_irq || p_irq) irq_act_o <= 1'b1;
      else if (ack_i)      irq_act_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_stat_irq.sv
module scsi_stat_irq
  import scsi_stat_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_ni,
  input  logic              io_ni,
  input  logic              cd_ni,
  input  logic              msg_ni,
  input  logic              dbp_ni,
  input  logic [DATA_W-1:0] data_ni,
  input  logic [7:0]        mode_i,
  input  logic [7:0]        tcmd_i,
  input  logic              dreg_rd_i,
  input  logic              dma_rx_i,
  input  logic              ack_i,
  output logic              phase_match_o,
  output logic              parity_err_o,
  output logic              irq_active_o,
  output logic              irq_o
);
  localparam int SW = DATA_W + 5;

  logic [SW-1:0]     pins_n, sync_n, sync_as;
  logic [DATA_W-1:0] data_as;
  logic              req_as, dbp_as, perr_evt;
  phase_t            bus_ph, cmd_ph;
  logic              unused_bits;

  assign pins_n = {req_ni, io_ni, cd_ni, msg_ni, dbp_ni, data_ni};

  scsi_line_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_n), .q_o(sync_n)
  );

  assign sync_as = ~sync_n;
  assign {req_as, bus_ph.io, bus_ph.cd, bus_ph.msg, dbp_as, data_as} = sync_as;

  assign cmd_ph.io  = tcmd_i[TC_IO_BIT];
  assign cmd_ph.cd  = tcmd_i[TC_CD_BIT];
  assign cmd_ph.msg = tcmd_i[TC_MSG_BIT];

  scsi_phase_cmp u_cmp (.bus_ph_i(bus_ph), .cmd_ph_i(cmd_ph), .match_o(phase_match_o));

  scsi_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data_i(data_as), .par_i(dbp_as), .strobe_i(dreg_rd_i || dma_rx_i),
    .chk_en_i(mode_i[MODE_PCHK_BIT]), .err_o(perr_evt)
  );

  scsi_irq_ctl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_as), .match_i(phase_match_o),
    .dma_mode_i(mode_i[MODE_DMA_BIT]), .perr_i(perr_evt),
    .pirq_en_i(mode_i[MODE_PIRQ_BIT]), .ack_i(ack_i),
    .perr_o(parity_err_o), .irq_act_o(irq_active_o)
  );

  assign irq_o = irq_active_o;
  assign unused_bits = ^{mode_i[7:6], mode_i[3:2], mode_i[0], tcmd_i[7:3]};
endmodule

// File: rtl/scsi_stat_irq_chk.sv
module scsi_stat_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] mode_i,
  input logic       dreg_rd_i,
  input logic       dma_rx_i,
  input logic       ack_i,
  input logic       parity_err_o,
  input logic       irq_active_o,
  input logic       irq_o
);
  assert_perr_needs_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(parity_err_o) |-> $past((dreg_rd_i || dma_rx_i) && mode_i[5]));

  assert_perr_off_when_chk_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[5] && !parity_err_o) |=> !parity_err_o);

  assert_irq_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_active_o) |-> $past(mode_i[1] || (mode_i[4] && mode_i[5])));

  assert_perr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_o && !ack_i) |=> parity_err_o);

  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_active_o && !ack_i) |=> irq_active_o);

  assert_irq_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == irq_active_o);
endmodule

bind scsi_stat_irq scsi_stat_irq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .dreg_rd_i(dreg_rd_i),
  .dma_rx_i(dma_rx_i), .ack_i(ack_i), .parity_err_o(parity_err_o),
  .irq_active_o(irq_active_o), .irq_o(irq_o)
);

// File: tb/scsi_stat_irq_tb_top.sv
module scsi_stat_irq_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_n = 1, io_n = 1, cd_n = 1, msg_n = 1, dbp_n = 1;
  logic [7:0] data_n = '1, mode = '0, tcmd = '0;
  logic rd = 0, dma = 0, ack = 0;
  logic pm, perr, irqa, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scsi_stat_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .io_ni(io_n), .cd_ni(cd_n),
    .msg_ni(msg_n), .dbp_ni(dbp_n), .data_ni(data_n), .mode_i(mode), .tcmd_i(tcmd),
    .dreg_rd_i(rd), .dma_rx_i(dma), .ack_i(ack), .phase_match_o(pm),
    .parity_err_o(perr), .irq_active_o(irqa), .irq_o(irq)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic settle(int n = 4);
    repeat (n) @(negedge clk);
  endtask

  // arguments are asserted levels; pins are driven inverted
  task automatic set_phase(logic io, logic cd, logic msg);
    io_n = ~io; cd_n = ~cd; msg_n = ~msg;
    settle();
  endtask

  task automatic set_byte(logic [7:0] d, logic p);
    data_n = ~d; dbp_n = ~p;
    settle();
  endtask

  task automatic do_ack();
    ack = 1; @(negedge clk); ack = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 perr", perr, 0);
    chk("R9 irq_active", irqa, 0);
    chk("R9 irq", irq, 0);
  endtask

  task automatic t_phase();
    for (int c = 0; c < 8; c++) begin
      tcmd = 8'(c);
      set_phase(c[0], c[1], c[2]);
      chk($sformatf("R1 match code %0d", c), pm, 1);
      for (int b = 0; b < 3; b++) begin
        tcmd = 8'(c ^ (1 << b));
        #1 chk($sformatf("R2 tcmd flip code %0d bit %0d", c, b), pm, 0);
      end
      tcmd = 8'(c);
    end
    tcmd = 8'b101;
    set_phase(1, 0, 1);
    io_n = 1'b1; @(negedge clk);
    chk("R2 not yet synced", pm, 1);
    settle(3);
    chk("R2 io line change", pm, 0);
    set_phase(1, 1, 1);
    chk("R1 cd mismatch", pm, 0);
    set_phase(1, 0, 0);
    chk("R1 msg mismatch", pm, 0);
    set_phase(1, 0, 1);
    chk("R1 rematch", pm, 1);
    chk("R4 no irq from phase changes without REQ", irq, 0);
  endtask

  task automatic t_mismatch_irq();
    mode = 8'b0000_0010; tcmd = 8'b000;
    set_phase(1, 0, 0);
    req_n = 0; settle();
    chk("R3 mismatch on REQ edge", irqa, 1);
    chk("R7 irq pin", irq, 1);
    req_n = 1; settle();
    chk("R7 irq holds", irqa, 1);
    do_ack();
    chk("R7 ack clears irq", irqa, 0);
  endtask

  task automatic t_no_irq();
    mode = 8'b0000_0000; tcmd = 8'b000;
    set_phase(1, 0, 0);
    req_n = 0; settle();
    chk("R4 DMA mode off", irqa, 0);
    req_n = 1; settle();
    mode = 8'b0000_0010;
    set_phase(0, 0, 0);
    req_n = 0; settle();
    chk("R4 matched edge", irqa, 0);
    set_phase(0, 1, 0);
    chk("R4 mismatch under held REQ", irqa, 0);
    req_n = 1; set_phase(0, 0, 0);
  endtask

  task automatic t_parity();
    mode = 8'b0011_0000;
    set_byte(8'h01, 0);
    rd = 1; @(negedge clk); rd = 0;
    chk("R5 good parity", perr, 0);
    set_byte(8'h03, 0);
    rd = 1; @(negedge clk); rd = 0;
    chk("R5 bad parity on read", perr, 1);
    chk("R6 parity irq", irqa, 1);
    do_ack();
    chk("R7 ack clears perr", perr, 0);
    dma = 1; @(negedge clk); dma = 0;
    chk("R5 bad parity on dma rx", perr, 1);
    do_ack();
    settle(2);
    chk("R5 no strobe no check", perr, 0);
    mode = 8'b0001_0000;
    rd = 1; @(negedge clk); rd = 0;
    chk("R5 checking disabled", perr, 0);
    chk("R6 no irq with check off", irqa, 0);
    mode = 8'b0010_0000;
    rd = 1; @(negedge clk); rd = 0;
    chk("R6 flag only", perr, 1);
    chk("R6 irq stays low", irq, 0);
    mode = 8'b0011_0000;
    rd = 1; ack = 1; @(negedge clk); rd = 0; ack = 0;
    chk("R7 event beats ack", perr, 1);
    do_ack();
    chk("R7 cleared", irqa, 0);
  endtask

  task automatic t_both();
    mode = 8'b0011_0010; tcmd = 8'b000;
    set_phase(0, 1, 0);
    set_byte(8'h00, 0);
    req_n = 0;
    @(negedge clk); @(negedge clk);
    rd = 1; @(negedge clk); rd = 0;
    chk("R8 irq", irqa, 1);
    chk("R8 perr", perr, 1);
    chk("R8 phase flag", pm, 0);
    do_ack();
    chk("R8 single ack clears all", irqa | perr, 0);
    req_n = 1; settle();
  endtask

  initial begin
    settle(2);
    t_reset();
    rst_n = 1; settle(2);
    t_reset();
    t_phase();
    t_mismatch_irq();
    t_no_irq();
    t_parity();
    t_both();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule